// File: doc/BRIEF.md
# Protected EEPROM Byte Update Sequencer

This block carries out single-byte changes to a 256-byte non-volatile store that is modelled as a register array. A command decoder hands it a start strobe together with an operation code, an address, a data byte and an unlock flag. The sequencer compares the stored byte with the new one. It then picks the cell phases the change really needs: an erase that drives every bit of the byte to 1, a write that clears selected bits to 0, both of them, or neither. Each case is timed as a fixed number of processing pulses that arrive on a pulse strobe from the serial front end.

The first 32 bytes each have a one-time-programmable guard bit at the same address. A protect operation clears the guard bit only when the supplied byte matches the stored byte. After that, the guarded byte can never be changed and the guard bit can never be set again. Changes to the main store are accepted only while the unlock flag is high. Any refused request leaves the memory untouched and ends with a failure pulse in place of a done pulse. A combinational read port lets the surrounding logic read any byte and guard bit.

Top module: `eeprom_update_seq`

## Requirements
- R1: After reset, busy, done and failure are low, every byte reads 0xFF and every guard bit reads 1.
- R2: An update (op 0) that needs only 1-to-0 bit changes is a write-only phase. It completes after 124 pulses with done, and the byte then reads the new value.
- R3: An update in which some bit needs a 0-to-1 change and the new value is not 0xFF needs an erase followed by a write. It completes after 255 pulses with done, and the byte then reads the new value.
- R4: An update to 0xFF from a byte holding at least one 0 is erase-only. It completes after 124 pulses with done, and the byte then reads 0xFF.
- R5: An update whose data equals the stored byte performs no cell operation. It completes after 2 pulses with done, and the byte is unchanged.
- R6: An update requested while the unlock flag is low fails after 2 pulses. The memory is unchanged, and done stays low.
- R7: A protect (op 1) on an address below 32 whose data equals the stored byte completes after 124 pulses with done. It clears that guard bit only.
- R8: A protect whose data differs from the stored byte fails after 2 pulses and leaves the guard bit at 1.
- R9: An update to a byte whose guard bit is 0 fails after 2 pulses, even when unlocked, and the byte is unchanged.
- R10: A protect on a guard bit already at 0, or on an address of 32 or above, fails after 2 pulses. A guard bit never returns from 0 to 1.
- R11: Busy rises in the cycle after an accepted start and falls in the cycle in which done or failure appears. A start seen while busy is ignored.
- R12: Done and failure are one-cycle pulses and never high together. Each appears in the cycle after the final pulse is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe, taken when not busy |
| op_i | input | 1 | 0 = update byte, 1 = protect byte |
| addr_i | input | 8 | Target byte address |
| data_i | input | 8 | New data, or comparison data for protect |
| unlock_i | input | 1 | Security unlock, sampled with start |
| pulse_i | input | 1 | One processing pulse per high cycle |
| rd_addr_i | input | 8 | Read-port address |
| rd_data_o | output | 8 | Byte stored at rd_addr_i |
| rd_prot_o | output | 1 | Guard bit at rd_addr_i (1 above 31) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Successful completion pulse |
| fail_o | output | 1 | Refused-operation pulse |

## Verification
The assertions assume that start_i is meaningful only while busy is low, and that the request fields are stable in the cycle in which start is taken. They also assume that the pulse strobe counts whole pulses, so one high cycle is one pulse. The stimulus raises start for exactly one cycle with all fields held. It spaces pulses one cycle high and one cycle low, and it injects exactly one deliberate start during a busy window to show that the request is ignored.

// File: rtl/eeprom_seq_pkg.sv
// Shared types for the byte update sequencer.
// Assumes: one-bit operation code, decoded upstream.
package eeprom_seq_pkg;
    typedef enum logic {
        OP_UPDATE  = 1'b0,
        OP_PROTECT = 1'b1
    } op_e;

    // Decision taken at request time.
    typedef struct packed {
        logic refuse;    // request rejected
        logic erase;     // erase phase needed
        logic write;     // write phase needed
        logic guard_clr; // guard bit to be cleared
    } plan_t;
endpackage

// File: rtl/eeprom_plan.sv
// Combinational planner: from the old byte, the new byte, the guard bit and
// the unlock flag it chooses the phases and the pulse budget of one request.
// Assumes: old_data and guard_bit belong to addr.
module eeprom_plan
    import eeprom_seq_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 8,
    parameter int PROT_BYTES    = 32,
    parameter int BOTH_PULSES   = 255,
    parameter int SINGLE_PULSES = 124,
    parameter int SHORT_PULSES  = 2,
    localparam int CNT_W        = $clog2(BOTH_PULSES + 1)
) (
    input  logic              op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] new_data,
    input  logic [DATA_W-1:0] old_data,
    input  logic              guard_bit,
    input  logic              unlock,
    output plan_t             plan,
    output logic [CNT_W-1:0]  budget
);
    logic guarded_range;
    logic rise_any;
    logic fall_any;

    // Bit-change analysis of the old versus the new byte.
    always_comb begin
        guarded_range = addr < ADDR_W'(PROT_BYTES);
        rise_any      = |(~old_data & new_data);
        fall_any      = |(old_data & ~new_data);
    end

    // Phase and budget selection.
    always_comb begin
        plan   = '0;
        budget = CNT_W'(SHORT_PULSES);
        if (op_e'(op) == OP_UPDATE) begin
            if (!unlock || (guarded_range && !guard_bit)) begin
                plan.refuse = 1'b1;
            end else begin
                plan.erase = rise_any;
                // after an erase the byte is all ones, so write if any zero wanted
                plan.write = rise_any ? (new_data != {DATA_W{1'b1}}) : fall_any;
                if (plan.erase && plan.write) budget = CNT_W'(BOTH_PULSES);
                else if (plan.erase || plan.write) budget = CNT_W'(SINGLE_PULSES);
            end
        end else begin
            if (!guarded_range || !guard_bit || (old_data != new_data)) begin
                plan.refuse = 1'b1;
            end else begin
                plan.guard_clr = 1'b1;
                budget         = CNT_W'(SINGLE_PULSES);
            end
        end
    end
endmodule

// File: rtl/eeprom_pulse_timer.sv
// Pulse timer: holds busy from load until 'budget' pulses have been seen and
// flags the cycle carrying the final pulse.
// Assumes: budget is at least 1; load is ignored while busy.
module eeprom_pulse_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] budget,
    input  logic             pulse,
    output logic             busy,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] tgt_q;

    // Final pulse detection.
    always_comb last = busy && pulse && (cnt_q == tgt_q - 1'b1);

    // Pulse counting and busy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            tgt_q <= '0;
        end else if (!busy && load) begin
            busy  <= 1'b1;
            cnt_q <= '0;
            tgt_q <= budget;
        end else if (last) begin
            busy <= 1'b0;
        end else if (busy && pulse) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/eeprom_cells.sv
// Storage: the byte array plus one-time guard bits for the low bytes.
// Guard bits reset to 1 and can only be cleared.
// Assumes: the model resets the array to the erased state (all ones).
module eeprom_cells #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int PROT_BYTES = 32,
    localparam int DEPTH     = 1 << ADDR_W,
    localparam int PIDX_W    = $clog2(PROT_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  byte_we,
    input  logic                  guard_clr,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     a_addr,
    output logic [DATA_W-1:0]     a_data,
    output logic                  a_guard,
    input  logic [ADDR_W-1:0]     b_addr,
    output logic [DATA_W-1:0]     b_data,
    output logic                  b_guard,
    output logic [PROT_BYTES-1:0] guard_vec
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    // Byte array update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (byte_we) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // One flop per guard bit, clear-only.
    for (genvar gi = 0; gi < PROT_BYTES; gi++) begin : g_guard
        always_ff @(posedge clk) begin
            if (!rst_n) guard_vec[gi] <= 1'b1;
            else if (guard_clr && (wr_addr == ADDR_W'(gi))) guard_vec[gi] <= 1'b0;
        end
    end

    // Two combinational read ports.
    always_comb begin
        a_data  = mem_q[a_addr];
        b_data  = mem_q[b_addr];
        a_guard = (a_addr < ADDR_W'(PROT_BYTES)) ? guard_vec[a_addr[PIDX_W-1:0]] : 1'b1;
        b_guard = (b_addr < ADDR_W'(PROT_BYTES)) ? guard_vec[b_addr[PIDX_W-1:0]] : 1'b1;
    end
endmodule

// File: rtl/eeprom_update_seq.sv
// Top: accepts one request at a time, plans it against the stored byte,
// times it in pulses and commits the change with the final pulse.
// Assumes: request fields are valid in the start cycle.
module eeprom_update_seq #(
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 8,
    parameter int PROT_BYTES    = 32,
    parameter int BOTH_PULSES   = 255,
    parameter int SINGLE_PULSES = 124,
    parameter int SHORT_PULSES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              unlock_i,
    input  logic              pulse_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_prot_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o
);
    import eeprom_seq_pkg::*;
    localparam int CNT_W = $clog2(BOTH_PULSES + 1);

    logic [DATA_W-1:0]     old_data;
    logic                  old_guard;
    plan_t                 plan;
    logic [CNT_W-1:0]      budget;
    logic                  last;
    logic                  accept;
    logic [ADDR_W-1:0]     lat_addr;
    logic [DATA_W-1:0]     lat_data;
    plan_t                 lat_plan;
    logic                  mem_we;
    logic                  guard_clr;
    logic [PROT_BYTES-1:0] prot_vec;

    eeprom_plan #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_BYTES(PROT_BYTES),
        .BOTH_PULSES(BOTH_PULSES), .SINGLE_PULSES(SINGLE_PULSES),
        .SHORT_PULSES(SHORT_PULSES)
    ) u_plan (
        .op(op_i), .addr(addr_i), .new_data(data_i), .old_data(old_data),
        .guard_bit(old_guard), .unlock(unlock_i), .plan(plan), .budget(budget)
    );

    eeprom_pulse_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(start_i), .budget(budget),
        .pulse(pulse_i), .busy(busy_o), .last(last)
    );

    eeprom_cells #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_BYTES(PROT_BYTES)) u_cells (
        .clk(clk), .rst_n(rst_n), .byte_we(mem_we), .guard_clr(guard_clr),
        .wr_addr(lat_addr), .wr_data(lat_data),
        .a_addr(addr_i), .a_data(old_data), .a_guard(old_guard),
        .b_addr(rd_addr_i), .b_data(rd_data_o), .b_guard(rd_prot_o),
        .guard_vec(prot_vec)
    );

    // Commit strobes fire with the final pulse only.
    always_comb begin
        accept    = start_i && !busy_o;
        mem_we    = last && !lat_plan.refuse && (lat_plan.erase || lat_plan.write);
        guard_clr = last && !lat_plan.refuse && lat_plan.guard_clr;
    end

    // Request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr <= '0;
            lat_data <= '0;
            lat_plan <= '0;
        end else if (accept) begin
            lat_addr <= addr_i;
            lat_data <= data_i;
            lat_plan <= plan;
        end
    end

    // Outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            fail_o <= 1'b0;
        end else begin
            done_o <= last && !lat_plan.refuse;
            fail_o <= last && lat_plan.refuse;
        end
    end
endmodule

// File: rtl/eeprom_update_seq_chk.sv
// Checker bound to the sequencer top: outcome pulses, busy framing,
// guard-bit monotonicity and refusal without commit.
// Assumes: reset is synchronous and active low.
module eeprom_update_seq_chk #(
    parameter int PROT_BYTES = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start_i,
    input logic                  busy_o,
    input logic                  done_o,
    input logic                  fail_o,
    input logic                  mem_we,
    input logic [PROT_BYTES-1:0] prot_vec
);
    p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));
    p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_busy_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    p_end_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o) |-> ($past(busy_o) && !busy_o));
    p_guard_oneway_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_vec & ~$past(prot_vec)) == '0);
    p_refuse_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> !$past(mem_we));
endmodule

bind eeprom_update_seq eeprom_update_seq_chk #(.PROT_BYTES(PROT_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .fail_o(fail_o), .mem_we(mem_we), .prot_vec(prot_vec)
);

// File: tb/sim_eeprom_update_seq.sv
module sim_eeprom_update_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       op_i = 1'b0;
    logic [7:0] addr_i = '0;
    logic [7:0] data_i = '0;
    logic       unlock_i = 1'b0;
    logic       pulse_i = 1'b0;
    logic [7:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;
    logic       rd_prot_o;
    logic       busy_o, done_o, fail_o;

    int total = 0;
    int bad = 0;

    eeprom_update_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .addr_i(addr_i), .data_i(data_i), .unlock_i(unlock_i), .pulse_i(pulse_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .rd_prot_o(rd_prot_o),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic read_byte(logic [7:0] a, output logic [7:0] d, output logic g);
        rd_addr_i = a;
        #1;
        d = rd_data_o;
        g = rd_prot_o;
    endtask

    // One request, pulses one cycle on / one off; returns pulse count and outcome.
    task automatic run_op(string req, logic op, logic [7:0] a, logic [7:0] d, logic unl,
                          int exp_pulses, logic exp_done, logic inject = 1'b0);
        int n;
        logic busy_ok;
        logic got_done, got_fail;
        @(negedge clk);
        start_i = 1'b1; op_i = op; addr_i = a; data_i = d; unlock_i = unl;
        @(negedge clk);
        start_i = 1'b0;
        check({req, " busy after start"}, int'(busy_o), 1);
        n = 0; busy_ok = 1'b1; got_done = 1'b0; got_fail = 1'b0;
        for (int k = 0; k < 600; k++) begin
            pulse_i = 1'b1;
            n++;
            if (inject && k == 3) begin
                start_i = 1'b1; addr_i = a + 8'd1; data_i = 8'h00;
            end
            @(negedge clk);
            pulse_i = 1'b0;
            start_i = 1'b0;
            if (done_o || fail_o) begin
                got_done = done_o; got_fail = fail_o;
                break;
            end
            if (!busy_o) busy_ok = 1'b0;
            @(negedge clk);
        end
        check({req, " pulse count"}, n, exp_pulses);
        check({req, " done"}, int'(got_done), int'(exp_done));
        check({req, " fail"}, int'(got_fail), int'(!exp_done));
        check({req, " busy held R11"}, int'(busy_ok), 1);
        check({req, " busy low at end R11"}, int'(busy_o), 0);
        @(negedge clk);
        check({req, " single pulse R12"}, int'(done_o || fail_o), 0);
    endtask

    task automatic expect_byte(string req, logic [7:0] a, logic [7:0] exp_d, logic exp_g);
        logic [7:0] d;
        logic g;
        read_byte(a, d, g);
        check({req, " data"}, int'(d), int'(exp_d));
        check({req, " guard"}, int'(g), int'(exp_g));
    endtask

    task automatic t_reset();
        check("R1 busy", int'(busy_o), 0);
        check("R1 done", int'(done_o), 0);
        check("R1 fail", int'(fail_o), 0);
        expect_byte("R1 byte5", 8'd5, 8'hFF, 1'b1);
        expect_byte("R1 byte200", 8'd200, 8'hFF, 1'b1);
    endtask

    task automatic t_write_only();
        run_op("R2", 1'b0, 8'd40, 8'h5A, 1'b1, 124, 1'b1);
        expect_byte("R2", 8'd40, 8'h5A, 1'b1);
    endtask

    task automatic t_both();
        run_op("R3", 1'b0, 8'd40, 8'hA5, 1'b1, 255, 1'b1);
        expect_byte("R3", 8'd40, 8'hA5, 1'b1);
    endtask

    task automatic t_erase_only();
        run_op("R4", 1'b0, 8'd40, 8'hFF, 1'b1, 124, 1'b1);
        expect_byte("R4", 8'd40, 8'hFF, 1'b1);
    endtask

    task automatic t_equal();
        run_op("R5", 1'b0, 8'd40, 8'hFF, 1'b1, 2, 1'b1);
        expect_byte("R5", 8'd40, 8'hFF, 1'b1);
    endtask

    task automatic t_locked();
        run_op("R6", 1'b0, 8'd41, 8'h00, 1'b0, 2, 1'b0);
        expect_byte("R6", 8'd41, 8'hFF, 1'b1);
    endtask

    task automatic t_protect();
        run_op("R7 prep", 1'b0, 8'd7, 8'h3C, 1'b1, 124, 1'b1);
        run_op("R7", 1'b1, 8'd7, 8'h3C, 1'b1, 124, 1'b1);
        expect_byte("R7 byte7", 8'd7, 8'h3C, 1'b0);
        expect_byte("R7 byte6", 8'd6, 8'hFF, 1'b1);
    endtask

    task automatic t_protect_mismatch();
        run_op("R8", 1'b1, 8'd8, 8'h00, 1'b1, 2, 1'b0);
        expect_byte("R8", 8'd8, 8'hFF, 1'b1);
    endtask

    task automatic t_guarded_update();
        run_op("R9", 1'b0, 8'd7, 8'h3D, 1'b1, 2, 1'b0);
        expect_byte("R9", 8'd7, 8'h3C, 1'b0);
    endtask

    task automatic t_reprotect();
        run_op("R10 again", 1'b1, 8'd7, 8'h3C, 1'b1, 2, 1'b0);
        expect_byte("R10 again", 8'd7, 8'h3C, 1'b0);
        run_op("R10 range", 1'b1, 8'd50, 8'hFF, 1'b1, 2, 1'b0);
        expect_byte("R10 range", 8'd50, 8'hFF, 1'b1);
    endtask

    task automatic t_ignore_start();
        run_op("R11 inject", 1'b0, 8'd60, 8'h0F, 1'b1, 124, 1'b1, 1'b1);
        expect_byte("R11 target", 8'd60, 8'h0F, 1'b1);
        expect_byte("R11 ignored", 8'd61, 8'hFF, 1'b1);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_only();
        t_both();
        t_erase_only();
        t_equal();
        t_locked();
        t_protect();
        t_protect_mismatch();
        t_guarded_update();
        t_reprotect();
        t_ignore_start();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule